// File: doc/BRIEF.md
# Machine-Mode Control and Status Register Unit

This block holds the machine-mode control and status registers of a small 32-bit integer core that never takes interrupts. The pipeline presents one CSR instruction at a time: a 12-bit register address, the operation code (the instruction's funct3 field) and a source operand. The source is either a register value or a 5-bit immediate. The unit returns the register's current contents in the same cycle and commits the new value at the next rising clock edge. Accesses that are not allowed raise an illegal-instruction flag and change nothing.

Most registers are trimmed down. The counters and the identification words are constants. The trap vector is a fixed address. The status and interrupt-enable registers keep only a few live bits. Only the scratch, exception-PC and cause registers are full 32-bit storage. The unit also performs the state changes of trap entry and trap return. For both it supplies the address the core should fetch from next.

The design has no state machine. Its only sequential element is the register file, and every access completes in one cycle. `csr_decode` maps the address to a register selector. `csr_alu` forms the write value. `csr_state` holds the storage and applies the trap and return updates.

Top module: `csr_unit`

## Requirements
- R1: The counter addresses 0xC00, 0xC01, 0xC02, 0xC80, 0xC81 and 0xC82 always read 0.
- R2: Address 0x305 always reads 0x00010040. Write operations to it are accepted without an illegal flag and leave the value unchanged.
- R3: Address 0x300 (status) reads bits [12:11] as 2'b11, bit 3 as the live global enable and bit 7 as the live previous enable, and all other bits as 0. Only bits 3 and 7 can be written.
- R4: Address 0x304 (enables) stores only bits 11, 7 and 3. All other bits read 0.
- R5: Address 0x301 reads 0x40000100 and address 0x344 reads 0. Writes to either are accepted without an illegal flag and change neither value.
- R6: Addresses 0x340, 0x341 and 0x342 are full 32-bit read/write registers. csr_funct 3'b001 writes, 3'b010 sets bits and 3'b011 clears bits using csr_rs1_val. Codes 3'b101, 3'b110 and 3'b111 do the same with csr_src_idx zero-extended as the operand.
- R7: csr_rdata shows the value held before the operation, in the cycle of the request. The new value is visible from the following cycle.
- R8: Addresses 0xF11 and 0xF12 read 0. Address 0xF13 reads the IMPL_ID parameter, which defaults to 0x00000001.
- R9: A set or clear operation whose csr_src_idx is 0 performs no write. On a read-only address it therefore raises no illegal flag.
- R10: csr_illegal is raised, and no register changes, in three cases: an unlisted address, csr_funct 3'b000 or 3'b100, or a write-performing operation on an address whose bits [11:10] are 2'b11.
- R11: On trap_take, the exception-PC register loads trap_pc with bits [1:0] cleared and the cause register loads trap_cause. The previous-enable bit takes the global enable and the global enable clears. redirect_pc shows 0x00010040 in that cycle.
- R12: On mret_take without trap_take, the global enable takes the previous-enable bit and the previous-enable bit becomes 1. redirect_pc shows the exception-PC register in that cycle.
- R13: When trap_take coincides with a CSR operation or with mret_take, only the trap update happens and the CSR write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_valid | input | 1 | A CSR instruction is presented this cycle |
| csr_addr | input | 12 | CSR address |
| csr_funct | input | 3 | Operation code (instruction funct3) |
| csr_src_idx | input | 5 | Source register index, or the immediate in immediate forms |
| csr_rs1_val | input | 32 | Source register value |
| csr_rdata | output | 32 | Value held before the operation |
| csr_illegal | output | 1 | Illegal-instruction flag for this request |
| trap_take | input | 1 | Enter a trap this cycle |
| trap_pc | input | 32 | PC of the faulting instruction |
| trap_cause | input | 32 | Cause code |
| mret_take | input | 1 | Return from trap this cycle |
| redirect_pc | output | 32 | Next fetch address for a trap or a return |

## Verification
The properties assume that the pipeline holds csr_valid and its operands steady for a whole cycle and drives no other input that would change the register contents between request and edge. The bench changes every input only just after a falling edge and clears csr_valid before the next request. It raises trap_take and mret_take together only in the scenario that checks precedence, and it always reads through the same CSR port that a core would use.

// File: rtl/csr_pkg.sv
package csr_pkg;
    localparam int XLEN = 32;
    localparam int ADDR_W = 12;
    localparam int IDX_W = 5;

    localparam logic [XLEN-1:0] TRAP_BASE   = 32'h0001_0040;
    localparam logic [XLEN-1:0] ISA_WORD    = 32'h4000_0100;
    localparam logic [XLEN-1:0] STATUS_FIX  = 32'h0000_1800;

    localparam int GIE_BIT  = 3;
    localparam int PGIE_BIT = 7;
    localparam int SW_EN_BIT  = 3;
    localparam int TMR_EN_BIT = 7;
    localparam int EXT_EN_BIT = 11;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_ZERO,
        SEL_STATUS,
        SEL_ISA,
        SEL_ENABLE,
        SEL_VECTOR,
        SEL_SCRATCH,
        SEL_EPC,
        SEL_CAUSE,
        SEL_IMPL
    } csr_sel_e;
endpackage

// File: rtl/csr_decode.sv
module csr_decode
    import csr_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output csr_sel_e          sel,
    output logic              read_only
);
    always_comb begin
        unique case (addr)
            12'h300: sel = SEL_STATUS;
            12'h301: sel = SEL_ISA;
            12'h304: sel = SEL_ENABLE;
            12'h305: sel = SEL_VECTOR;
            12'h340: sel = SEL_SCRATCH;
            12'h341: sel = SEL_EPC;
            12'h342: sel = SEL_CAUSE;
            12'h344: sel = SEL_ZERO;
            12'hC00, 12'hC01, 12'hC02,
            12'hC80, 12'hC81, 12'hC82,
            12'hF11, 12'hF12: sel = SEL_ZERO;
            12'hF13: sel = SEL_IMPL;
            default: sel = SEL_NONE;
        endcase
    end

    assign read_only = (addr[ADDR_W-1 -: 2] == 2'b11);
endmodule

// File: rtl/csr_alu.sv
module csr_alu
    import csr_pkg::*;
(
    input  logic [2:0]       funct,
    input  logic [IDX_W-1:0] src_idx,
    input  logic [XLEN-1:0]  rs1_val,
    input  logic [XLEN-1:0]  old_val,
    output logic [XLEN-1:0]  new_val,
    output logic             writes,
    output logic             bad_funct
);
    logic [XLEN-1:0] operand;
    logic            src_zero;

    assign operand  = funct[2] ? {{(XLEN-IDX_W){1'b0}}, src_idx} : rs1_val;
    assign src_zero = (src_idx == '0);

    always_comb begin
        new_val   = old_val;
        writes    = 1'b0;
        bad_funct = 1'b0;
        unique case (funct[1:0])
            2'b01: begin
                new_val = operand;
                writes  = 1'b1;
            end
            2'b10: begin
                new_val = old_val | operand;
                writes  = !src_zero;
            end
            2'b11: begin
                new_val = old_val & ~operand;
                writes  = !src_zero;
            end
            default: bad_funct = 1'b1;
        endcase
    end
endmodule

// File: rtl/csr_state.sv
module csr_state
    import csr_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  csr_sel_e        wr_sel,
    input  logic [XLEN-1:0] wr_val,
    input  logic            trap_take,
    input  logic [XLEN-1:0] trap_pc,
    input  logic [XLEN-1:0] trap_cause,
    input  logic            mret_take,
    output logic [XLEN-1:0] scratch_q,
    output logic [XLEN-1:0] epc_q,
    output logic [XLEN-1:0] cause_q,
    output logic            gie_q,
    output logic            pgie_q,
    output logic [2:0]      en_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scratch_q <= '0;
            epc_q     <= '0;
            cause_q   <= '0;
            gie_q     <= 1'b0;
            pgie_q    <= 1'b0;
            en_q      <= '0;
        end else if (trap_take) begin
            epc_q   <= {trap_pc[XLEN-1:2], 2'b00};
            cause_q <= trap_cause;
            pgie_q  <= gie_q;
            gie_q   <= 1'b0;
        end else if (mret_take) begin
            gie_q  <= pgie_q;
            pgie_q <= 1'b1;
        end else if (wr_en) begin
            unique case (wr_sel)
                SEL_SCRATCH: scratch_q <= wr_val;
                SEL_EPC:     epc_q     <= wr_val;
                SEL_CAUSE:   cause_q   <= wr_val;
                SEL_STATUS: begin
                    gie_q  <= wr_val[GIE_BIT];
                    pgie_q <= wr_val[PGIE_BIT];
                end
                SEL_ENABLE:
                    en_q <= {wr_val[EXT_EN_BIT], wr_val[TMR_EN_BIT], wr_val[SW_EN_BIT]};
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/csr_unit.sv
module csr_unit
    import csr_pkg::*;
#(
    parameter logic [31:0] IMPL_ID = 32'h0000_0001
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        csr_valid,
    input  logic [11:0] csr_addr,
    input  logic [2:0]  csr_funct,
    input  logic [4:0]  csr_src_idx,
    input  logic [31:0] csr_rs1_val,
    output logic [31:0] csr_rdata,
    output logic        csr_illegal,
    input  logic        trap_take,
    input  logic [31:0] trap_pc,
    input  logic [31:0] trap_cause,
    input  logic        mret_take,
    output logic [31:0] redirect_pc
);
    csr_sel_e        sel;
    logic            read_only;
    logic [XLEN-1:0] new_val;
    logic            writes;
    logic            bad_funct;
    logic            commit;
    logic [XLEN-1:0] scratch_q, epc_q, cause_q;
    logic            gie_q, pgie_q;
    logic [2:0]      en_q;

    csr_decode u_dec (
        .addr      (csr_addr),
        .sel       (sel),
        .read_only (read_only)
    );

    csr_alu u_alu (
        .funct     (csr_funct),
        .src_idx   (csr_src_idx),
        .rs1_val   (csr_rs1_val),
        .old_val   (csr_rdata),
        .new_val   (new_val),
        .writes    (writes),
        .bad_funct (bad_funct)
    );

    always_comb begin
        unique case (sel)
            SEL_STATUS: begin
                csr_rdata = STATUS_FIX;
                csr_rdata[GIE_BIT]  = gie_q;
                csr_rdata[PGIE_BIT] = pgie_q;
            end
            SEL_ENABLE: begin
                csr_rdata = '0;
                csr_rdata[SW_EN_BIT]  = en_q[0];
                csr_rdata[TMR_EN_BIT] = en_q[1];
                csr_rdata[EXT_EN_BIT] = en_q[2];
            end
            SEL_ISA:     csr_rdata = ISA_WORD;
            SEL_VECTOR:  csr_rdata = TRAP_BASE;
            SEL_SCRATCH: csr_rdata = scratch_q;
            SEL_EPC:     csr_rdata = epc_q;
            SEL_CAUSE:   csr_rdata = cause_q;
            SEL_IMPL:    csr_rdata = IMPL_ID;
            default:     csr_rdata = '0;
        endcase
    end

    assign csr_illegal = csr_valid &&
                         ((sel == SEL_NONE) || bad_funct || (read_only && writes));
    assign commit      = csr_valid && !csr_illegal && writes && !trap_take;
    assign redirect_pc = trap_take ? TRAP_BASE : epc_q;

    csr_state u_state (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (commit),
        .wr_sel     (sel),
        .wr_val     (new_val),
        .trap_take  (trap_take),
        .trap_pc    (trap_pc),
        .trap_cause (trap_cause),
        .mret_take  (mret_take),
        .scratch_q  (scratch_q),
        .epc_q      (epc_q),
        .cause_q    (cause_q),
        .gie_q      (gie_q),
        .pgie_q     (pgie_q),
        .en_q       (en_q)
    );
endmodule

// File: rtl/csr_unit_chk.sv
module csr_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        csr_valid,
    input logic [11:0] csr_addr,
    input logic [2:0]  csr_funct,
    input logic [4:0]  csr_src_idx,
    input logic [31:0] csr_rdata,
    input logic        csr_illegal,
    input logic        trap_take,
    input logic [31:0] trap_pc,
    input logic [31:0] trap_cause,
    input logic        mret_take,
    input logic [31:0] scratch_q,
    input logic [31:0] epc_q,
    input logic [31:0] cause_q,
    input logic        gie_q,
    input logic        pgie_q,
    input logic [2:0]  en_q
);
    // R2
    vector_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_addr == 12'h305) |-> (csr_rdata == 32'h0001_0040));

    // R4
    enable_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_addr == 12'h304) |-> ((csr_rdata & ~32'h0000_0888) == 32'h0));

    // R9
    zero_src_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_valid && (csr_addr == 12'hC00) && (csr_funct[1:0] != 2'b00)
         && (csr_funct[1:0] != 2'b01) && (csr_src_idx == 5'd0)) |-> !csr_illegal);

    // R10
    illegal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_valid && csr_illegal && !trap_take && !mret_take) |=>
        ($stable(scratch_q) && $stable(epc_q) && $stable(cause_q)
         && $stable(gie_q) && $stable(pgie_q) && $stable(en_q)));

    // R11
    trap_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_take |=> ((epc_q == {$past(trap_pc[31:2]), 2'b00})
                       && (cause_q == $past(trap_cause))
                       && (pgie_q == $past(gie_q)) && !gie_q));

    // R12
    trap_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mret_take && !trap_take) |=> ((gie_q == $past(pgie_q)) && pgie_q));

    // R13
    trap_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_take |=> $stable(scratch_q));
endmodule

bind csr_unit csr_unit_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .csr_valid   (csr_valid),
    .csr_addr    (csr_addr),
    .csr_funct   (csr_funct),
    .csr_src_idx (csr_src_idx),
    .csr_rdata   (csr_rdata),
    .csr_illegal (csr_illegal),
    .trap_take   (trap_take),
    .trap_pc     (trap_pc),
    .trap_cause  (trap_cause),
    .mret_take   (mret_take),
    .scratch_q   (scratch_q),
    .epc_q       (epc_q),
    .cause_q     (cause_q),
    .gie_q       (gie_q),
    .pgie_q      (pgie_q),
    .en_q        (en_q)
);

// File: tb/csr_unit_tb.sv
module csr_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_valid = 1'b0;
    logic [11:0] csr_addr = '0;
    logic [2:0]  csr_funct = '0;
    logic [4:0]  csr_src_idx = '0;
    logic [31:0] csr_rs1_val = '0;
    logic [31:0] csr_rdata;
    logic        csr_illegal;
    logic        trap_take = 1'b0;
    logic [31:0] trap_pc = '0;
    logic [31:0] trap_cause = '0;
    logic        mret_take = 1'b0;
    logic [31:0] redirect_pc;

    int checks = 0;
    int errors = 0;
    logic [31:0] got;
    logic        got_ill;

    always #10 clk = ~clk;

    csr_unit u_dut (
        .clk(clk), .rst_n(rst_n), .csr_valid(csr_valid), .csr_addr(csr_addr),
        .csr_funct(csr_funct), .csr_src_idx(csr_src_idx), .csr_rs1_val(csr_rs1_val),
        .csr_rdata(csr_rdata), .csr_illegal(csr_illegal), .trap_take(trap_take),
        .trap_pc(trap_pc), .trap_cause(trap_cause), .mret_take(mret_take),
        .redirect_pc(redirect_pc)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Present one request after a falling edge, sample before the rising edge.
    task automatic op(input logic [2:0] f, input logic [11:0] a, input logic [4:0] idx,
                      input logic [31:0] v);
        @(negedge clk);
        csr_valid = 1'b1; csr_funct = f; csr_addr = a; csr_src_idx = idx; csr_rs1_val = v;
        #2;
        got = csr_rdata; got_ill = csr_illegal;
        @(posedge clk); #1;
        csr_valid = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a);
        op(3'b010, a, 5'd0, 32'h0);
    endtask

    task automatic t_reset;
        rd(12'h340); check("R7 reset scratch", got, 32'h0);
        rd(12'h300); check("R3 reset status", got, 32'h0000_1800);
    endtask

    task automatic t_constants;
        logic [11:0] ctr [6] = '{12'hC00, 12'hC01, 12'hC02, 12'hC80, 12'hC81, 12'hC82};
        for (int i = 0; i < 6; i++) begin
            rd(ctr[i]); check("R1 counter", got, 32'h0);
        end
        rd(12'hF11); check("R8 vendor", got, 32'h0);
        rd(12'hF12); check("R8 arch", got, 32'h0);
        rd(12'hF13); check("R8 impl", got, 32'h1);
        op(3'b001, 12'h305, 5'd1, 32'hFFFF_FFFF); check("R2 vec write legal", {31'b0, got_ill}, 32'h0);
        rd(12'h305); check("R2 vector", got, 32'h0001_0040);
        op(3'b001, 12'h301, 5'd1, 32'h0); check("R5 isa write legal", {31'b0, got_ill}, 32'h0);
        rd(12'h301); check("R5 isa", got, 32'h4000_0100);
        op(3'b110, 12'h344, 5'd7, 32'h0); check("R5 ip write legal", {31'b0, got_ill}, 32'h0);
        rd(12'h344); check("R5 ip", got, 32'h0);
    endtask

    task automatic t_masks;
        op(3'b001, 12'h300, 5'd1, 32'hFFFF_FFFF);
        rd(12'h300); check("R3 status mask", got, 32'h0000_1888);
        op(3'b011, 12'h300, 5'd1, 32'h0000_0080);
        rd(12'h300); check("R3 clear pgie", got, 32'h0000_1808);
        op(3'b001, 12'h304, 5'd1, 32'hFFFF_FFFF);
        rd(12'h304); check("R4 enable mask", got, 32'h0000_0888);
        op(3'b111, 12'h304, 5'd8, 32'h0);
        rd(12'h304); check("R4 clear imm", got, 32'h0000_0880);
    endtask

    task automatic t_rw;
        op(3'b001, 12'h340, 5'd3, 32'hA5A5_0F0F); check("R7 old value", got, 32'h0);
        rd(12'h340); check("R6 write", got, 32'hA5A5_0F0F);
        op(3'b010, 12'h340, 5'd3, 32'h0000_F000);
        rd(12'h340); check("R6 set", got, 32'hA5A5_FF0F);
        op(3'b011, 12'h340, 5'd3, 32'hA000_000F);
        rd(12'h340); check("R6 clear", got, 32'h05A5_FF00);
        op(3'b101, 12'h341, 5'd21, 32'hDEAD_BEEF);
        rd(12'h341); check("R6 imm write", got, 32'h0000_0015);
        op(3'b110, 12'h342, 5'd9, 32'h0);
        rd(12'h342); check("R6 imm set", got, 32'h0000_0009);
        op(3'b010, 12'h340, 5'd0, 32'hFFFF_FFFF);
        rd(12'h340); check("R9 zero idx set no write", got, 32'h05A5_FF00);
        op(3'b011, 12'hC00, 5'd0, 32'h0); check("R9 ro read legal", {31'b0, got_ill}, 32'h0);
    endtask

    task automatic t_illegal;
        op(3'b001, 12'h7FF, 5'd1, 32'h1); check("R10 unlisted", {31'b0, got_ill}, 32'h1);
        op(3'b001, 12'hF11, 5'd1, 32'h1); check("R10 ro write", {31'b0, got_ill}, 32'h1);
        op(3'b100, 12'h340, 5'd1, 32'h0); check("R10 bad funct", {31'b0, got_ill}, 32'h1);
        op(3'b000, 12'h340, 5'd1, 32'h0); check("R10 bad funct0", {31'b0, got_ill}, 32'h1);
        rd(12'h340); check("R10 unchanged", got, 32'h05A5_FF00);
    endtask

    task automatic t_trap;
        op(3'b001, 12'h300, 5'd1, 32'h0000_0008);
        @(negedge clk);
        trap_take = 1'b1; trap_pc = 32'h0000_1237; trap_cause = 32'h2;
        #2; check("R11 redirect vector", redirect_pc, 32'h0001_0040);
        @(posedge clk); #1; trap_take = 1'b0;
        rd(12'h341); check("R11 epc", got, 32'h0000_1234);
        rd(12'h342); check("R11 cause", got, 32'h2);
        rd(12'h300); check("R11 status", got, 32'h0000_1880);
        @(negedge clk);
        mret_take = 1'b1;
        #2; check("R12 redirect epc", redirect_pc, 32'h0000_1234);
        @(posedge clk); #1; mret_take = 1'b0;
        rd(12'h300); check("R12 status", got, 32'h0000_1888);
    endtask

    task automatic t_precedence;
        @(negedge clk);
        csr_valid = 1'b1; csr_funct = 3'b001; csr_addr = 12'h340; csr_src_idx = 5'd1;
        csr_rs1_val = 32'h1111_1111;
        trap_take = 1'b1; mret_take = 1'b1; trap_pc = 32'h0000_2002; trap_cause = 32'h7;
        @(posedge clk); #1;
        csr_valid = 1'b0; trap_take = 1'b0; mret_take = 1'b0;
        rd(12'h340); check("R13 write dropped", got, 32'h05A5_FF00);
        rd(12'h341); check("R13 trap epc", got, 32'h0000_2000);
        rd(12'h300); check("R13 trap over mret", got, 32'h0000_1880);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_constants();
        t_masks();
        t_rw();
        t_illegal();
        t_trap();
        t_precedence();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2_000_000;
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule